// File: doc/BRIEF.md
# Video Memory Fill and Copy Engine

This block runs the memory-to-memory transfers of a video display controller. A single start pulse launches either a fill or a copy. A fill writes one repeated value into the 64 KiB byte-addressed video RAM. It can instead write into the 64-entry colour memory or the 64-entry vertical-scroll memory. A copy moves bytes from one part of video RAM to another. At launch the engine latches a 16-bit step count, a 16-bit source counter, a 16-bit destination address, an 8-bit auto-increment and a destination code. It then performs one memory write per clock.

All three memories live outside the block. They are reached through plain synchronous ports: one byte write port and one byte read port for video RAM, with read data returned one clock after the read is issued, and one word write port each for the colour and scroll memories. The block also watches the host data-port writes and keeps the last four words in a short history. Colour and scroll fills take their data from the oldest word of that history, not from the fill value.

When the last write has gone out, the block pulses a write-back strobe. Alongside the strobe it presents a zero step count and the final source counter. The surrounding register file stores the counter's low byte and high byte in its two source registers and clears its two length registers.

Top module: `vdma_engine`

## Requirements
- R1: After reset, busy is low, all three write enables are low, the write-back strobe is low and every history entry reads as zero.
- R2: A transfer makes N steps, where N is the programmed length, and a length of 0 means 65535 steps. Each step produces at most one memory write, and the writes go out in consecutive clocks. Busy is high for exactly N+1 clocks, starting the clock after start is sampled and ending with the clock that carries the final write.
- R3: A video RAM fill (copyMode=0, code=1) writes fillWord[15:8] at the current destination XOR 1, within 16 bits, on every step.
- R4: After every step the destination grows by autoInc (zero is allowed) and the source counter grows by 1. Both wrap at 16 bits.
- R5: A copy (copyMode=1) always targets video RAM, whatever the code. On each step it reads the byte at source XOR 1 and writes that byte, one clock later, to destination XOR 1.
- R6: A colour fill (code=3) writes the oldest history word at index destination bits 6:1. A scroll fill (code=5) writes only the low 10 bits of that word, at the same index.
- R7: Every dataWr pulse shifts the history by one place, with dataWord entering at the newest end. The oldest entry is therefore the word written four pulses earlier.
- R8: A fill with any code other than 1, 3 or 5 makes no write at all, yet still runs its N steps and advances its counters.
- R9: In the clock where busy falls, wbStrobe is high for that one clock only, wbLen is 0 and wbSrc holds the final source counter (the initial source plus N, modulo 2^16).
- R10: A start pulse that arrives while busy is high is ignored and leaves the running transfer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled only while idle |
| copyMode | input | 1 | 1 = video RAM copy, 0 = fill |
| code | input | 4 | Fill destination code: 1 video RAM, 3 colour, 5 scroll |
| len | input | 16 | Step count, 0 meaning 65535 |
| srcLow | input | 16 | Initial source counter |
| dstAddr | input | 16 | Initial destination address |
| autoInc | input | 8 | Destination step per write |
| fillWord | input | 16 | Fill value; bits 15:8 are written to video RAM |
| dataWr | input | 1 | Host data-port write strobe |
| dataWord | input | 16 | Host data-port word |
| vramRdData | input | 8 | Video RAM read data, valid one clock after vramRdEn |
| busy | output | 1 | Transfer in progress |
| vramRdEn | output | 1 | Video RAM read request |
| vramRdAddr | output | 16 | Video RAM read address |
| vramWe | output | 1 | Video RAM byte write enable |
| vramWrAddr | output | 16 | Video RAM write address |
| vramWrData | output | 8 | Video RAM write byte |
| cramWe | output | 1 | Colour memory write enable |
| cramIdx | output | 6 | Colour memory word index |
| cramData | output | 16 | Colour memory write word |
| vsramWe | output | 1 | Scroll memory write enable |
| vsramIdx | output | 6 | Scroll memory word index |
| vsramData | output | 10 | Scroll memory write word |
| wbStrobe | output | 1 | One-clock register write-back pulse |
| wbLen | output | 16 | Length to write back (zero at the strobe) |
| wbSrc | output | 16 | Final source counter to write back |

## Verification
Video RAM fills are run with a unit stride and with a stride of 2 that crosses the top of the address space. The first shows the XOR-1 byte swap, and the second shows the 16-bit wrap of both the destination and the source counter. Colour and scroll fills are run after four history pushes and again after a fifth. Only the oldest-entry rule, not the newest word or the fill value, produces the expected data in both cases; the scroll index is also made to roll over past 63. Copies are run with a normal stride and with a zero stride under an ignored code. An unused code, a length of 1, a length of 0 (65535 steps) and a second start pulse in mid-transfer separate the step counting, the write gating and the idle-only launch.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_VRAM_FILL,
    TGT_VRAM_COPY,
    TGT_CRAM,
    TGT_VSRAM
  } tgt_e;

  typedef struct packed {
    logic load;
    logic step;
    tgt_e tgt;
  } ctrl_s;

  localparam logic [3:0] CODE_VRAM  = 4'd1;
  localparam logic [3:0] CODE_CRAM  = 4'd3;
  localparam logic [3:0] CODE_VSRAM = 4'd5;

  function automatic tgt_e decodeTgt(input logic isCopy, input logic [3:0] code);
    if (isCopy) return TGT_VRAM_COPY;
    case (code)
      CODE_VRAM:  return TGT_VRAM_FILL;
      CODE_CRAM:  return TGT_CRAM;
      CODE_VSRAM: return TGT_VSRAM;
      default:    return TGT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vdma_hist.sv
module vdma_hist #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] oldest
);
  logic [W-1:0] stage [DEPTH];

  // R7: shift toward the oldest end on every data-port write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else if (push) begin
      for (int i = DEPTH - 1; i > 0; i--) stage[i] <= stage[i-1];
      stage[0] <= din;
    end
  end

  assign oldest = stage[DEPTH-1];
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             copyMode,
  input  logic [3:0]       code,
  input  logic [LEN_W-1:0] len,
  output ctrl_s            ctl,
  output logic             busy,
  output logic             wbStrobe,
  output logic [LEN_W-1:0] wbLen
);
  logic [LEN_W-1:0] remaining;
  logic             busyQ;
  logic             wbQ;
  tgt_e             tgtQ;
  logic             accept;

  assign accept = start && !busyQ;   // R10: launch only while idle

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      busyQ     <= 1'b0;
      wbQ       <= 1'b0;
      tgtQ      <= TGT_NONE;
    end else begin
      wbQ <= 1'b0;
      if (accept) begin
        remaining <= (len == '0) ? '1 : len;   // R2: zero means all ones
        tgtQ      <= decodeTgt(copyMode, code);
        busyQ     <= 1'b1;
      end else if (busyQ) begin
        if (remaining != '0) begin
          remaining <= remaining - 1'b1;
        end else begin
          busyQ <= 1'b0;   // final write drains in this cycle
          wbQ   <= 1'b1;
        end
      end
    end
  end

  assign ctl.load  = accept;
  assign ctl.step  = busyQ && (remaining != '0);
  assign ctl.tgt   = tgtQ;
  assign busy      = busyQ;
  assign wbStrobe  = wbQ;
  assign wbLen     = remaining;

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busyQ);
  a_r9_wb_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wbQ |-> (!busyQ && $past(busyQ) && remaining == '0));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && start) |=> $stable(tgtQ));
endmodule

// File: rtl/vdma_datapath.sv
module vdma_datapath
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int INC_W  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  parameter int VS_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_s             ctl,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [ADDR_W-1:0] srcLow,
  input  logic [INC_W-1:0]  autoInc,
  input  logic [DATA_W-1:0] fillWord,
  input  logic [DATA_W-1:0] histOldest,
  input  logic [7:0]        vramRdData,
  output logic              vramRdEn,
  output logic [ADDR_W-1:0] vramRdAddr,
  output logic              vramWe,
  output logic [ADDR_W-1:0] vramWrAddr,
  output logic [7:0]        vramWrData,
  output logic              cramWe,
  output logic [IDX_W-1:0]  cramIdx,
  output logic [DATA_W-1:0] cramData,
  output logic              vsramWe,
  output logic [IDX_W-1:0]  vsramIdx,
  output logic [VS_W-1:0]   vsramData,
  output logic [ADDR_W-1:0] wbSrc
);
  localparam logic [ADDR_W-1:0] SWAP = ADDR_W'(1);
  localparam int PAD_W = ADDR_W - INC_W;

  logic [ADDR_W-1:0] dstQ, srcQ, wrAddr;
  logic [INC_W-1:0]  incQ;
  logic [7:0]        fillHiQ;
  logic              wrValid;
  tgt_e              wrTgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dstQ    <= '0;
      srcQ    <= '0;
      incQ    <= '0;
      fillHiQ <= '0;
      wrAddr  <= '0;
      wrValid <= 1'b0;
      wrTgt   <= TGT_NONE;
    end else begin
      wrValid <= ctl.step;
      if (ctl.load) begin
        dstQ    <= dstAddr;
        srcQ    <= srcLow;
        incQ    <= autoInc;
        fillHiQ <= fillWord[DATA_W-1 -: 8];
      end else if (ctl.step) begin
        dstQ   <= dstQ + {{PAD_W{1'b0}}, incQ};   // R4
        srcQ   <= srcQ + 1'b1;
        wrAddr <= dstQ ^ SWAP;
        wrTgt  <= ctl.tgt;
      end
    end
  end

  // R5: read issued in the step cycle, byte arrives with the write stage
  assign vramRdEn   = ctl.step && (ctl.tgt == TGT_VRAM_COPY);
  assign vramRdAddr = srcQ ^ SWAP;

  assign vramWe     = wrValid && (wrTgt == TGT_VRAM_FILL || wrTgt == TGT_VRAM_COPY);
  assign vramWrAddr = wrAddr;
  assign vramWrData = (wrTgt == TGT_VRAM_COPY) ? vramRdData : fillHiQ;
  assign cramWe     = wrValid && (wrTgt == TGT_CRAM);
  assign cramIdx    = wrAddr[IDX_W:1];
  assign cramData   = histOldest;
  assign vsramWe    = wrValid && (wrTgt == TGT_VSRAM);
  assign vsramIdx   = wrAddr[IDX_W:1];
  assign vsramData  = histOldest[VS_W-1:0];
  assign wbSrc      = srcQ;

  a_r5_copy_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (vramWe && wrTgt == TGT_VRAM_COPY) |-> $past(vramRdEn));
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vramWe, cramWe, vsramWe}));
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  parameter int VS_W   = 10,
  parameter int HIST_D = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              copyMode,
  input  logic [3:0]        code,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] srcLow,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [INC_W-1:0]  autoInc,
  input  logic [DATA_W-1:0] fillWord,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataWord,
  input  logic [7:0]        vramRdData,
  output logic              busy,
  output logic              vramRdEn,
  output logic [ADDR_W-1:0] vramRdAddr,
  output logic              vramWe,
  output logic [ADDR_W-1:0] vramWrAddr,
  output logic [7:0]        vramWrData,
  output logic              cramWe,
  output logic [IDX_W-1:0]  cramIdx,
  output logic [DATA_W-1:0] cramData,
  output logic              vsramWe,
  output logic [IDX_W-1:0]  vsramIdx,
  output logic [VS_W-1:0]   vsramData,
  output logic              wbStrobe,
  output logic [LEN_W-1:0]  wbLen,
  output logic [ADDR_W-1:0] wbSrc
);
  ctrl_s             ctl;
  logic [DATA_W-1:0] histOldest;

  vdma_hist #(.W(DATA_W), .DEPTH(HIST_D)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(dataWr), .din(dataWord), .oldest(histOldest)
  );

  vdma_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .copyMode(copyMode), .code(code),
    .len(len), .ctl(ctl), .busy(busy), .wbStrobe(wbStrobe), .wbLen(wbLen)
  );

  vdma_datapath #(
    .ADDR_W(ADDR_W), .INC_W(INC_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .VS_W(VS_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .dstAddr(dstAddr), .srcLow(srcLow),
    .autoInc(autoInc), .fillWord(fillWord), .histOldest(histOldest),
    .vramRdData(vramRdData), .vramRdEn(vramRdEn), .vramRdAddr(vramRdAddr),
    .vramWe(vramWe), .vramWrAddr(vramWrAddr), .vramWrData(vramWrData),
    .cramWe(cramWe), .cramIdx(cramIdx), .cramData(cramData),
    .vsramWe(vsramWe), .vsramIdx(vsramIdx), .vsramData(vsramData), .wbSrc(wbSrc)
  );

  a_r2_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(vramWe || cramWe || vsramWe));
  a_r9_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wbStrobe |=> !wbStrobe);
endmodule

// File: tb/vdma_engine_tb.sv
`timescale 1ns/1ps
module vdma_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, copyMode = 0, dataWr = 0;
  logic [3:0]  code = '0;
  logic [15:0] len = '0, srcLow = '0, dstAddr = '0, fillWord = '0, dataWord = '0;
  logic [7:0]  autoInc = '0;
  logic [7:0]  rdq = '0;
  logic busy, vramRdEn, vramWe, cramWe, vsramWe, wbStrobe;
  logic [15:0] vramRdAddr, vramWrAddr, cramData, wbLen, wbSrc;
  logic [7:0]  vramWrData;
  logic [5:0]  cramIdx, vsramIdx;
  logic [9:0]  vsramData;

  always #2.5 clk = ~clk;

  vdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .copyMode(copyMode), .code(code),
    .len(len), .srcLow(srcLow), .dstAddr(dstAddr), .autoInc(autoInc),
    .fillWord(fillWord), .dataWr(dataWr), .dataWord(dataWord), .vramRdData(rdq),
    .busy(busy), .vramRdEn(vramRdEn), .vramRdAddr(vramRdAddr), .vramWe(vramWe),
    .vramWrAddr(vramWrAddr), .vramWrData(vramWrData), .cramWe(cramWe),
    .cramIdx(cramIdx), .cramData(cramData), .vsramWe(vsramWe), .vsramIdx(vsramIdx),
    .vsramData(vsramData), .wbStrobe(wbStrobe), .wbLen(wbLen), .wbSrc(wbSrc)
  );

  function automatic logic [7:0] rdFn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // synchronous video RAM read model: one clock latency
  always @(posedge clk) if (vramRdEn) rdq <= rdFn(vramRdAddr);

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] hm [4];
  int pushCnt = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor state
  bit monOn = 0;
  int expTgt = 0;          // 0 none, 1 vram fill, 2 copy, 3 cram, 4 vsram
  logic [15:0] mDst, mSrc;
  logic [7:0]  mInc, mFillHi;
  int wrCnt, busyCnt, wbCnt;
  logic [15:0] wbSrcSeen, wbLenSeen;
  bit wbBusy;

  always @(negedge clk) begin
    if (monOn) begin
      if (busy) busyCnt++;
      if (wbStrobe) begin
        wbCnt++; wbSrcSeen = wbSrc; wbLenSeen = wbLen; wbBusy = busy;
      end
      if (vramWe || cramWe || vsramWe) begin
        logic [34:0] act, exp;
        string tag;
        wrCnt++;
        act = {vramWe, cramWe, vsramWe,
               vramWe ? vramWrAddr : {10'd0, (cramWe ? cramIdx : vsramIdx)},
               vramWe ? {8'd0, vramWrData} : (cramWe ? cramData : {6'd0, vsramData})};
        case (expTgt)
          1: begin exp = {3'b100, mDst ^ 16'h1, 8'd0, mFillHi};           tag = "R3 R4 vram fill"; end
          2: begin exp = {3'b100, mDst ^ 16'h1, 8'd0, rdFn(mSrc ^ 16'h1)}; tag = "R5 R4 copy"; end
          3: begin exp = {3'b010, 10'd0, mDst[6:1], hm[3]};               tag = "R6 R7 cram fill"; end
          4: begin exp = {3'b001, 10'd0, mDst[6:1], 6'd0, hm[3][9:0]};    tag = "R6 R7 vsram fill"; end
          default: begin exp = '0; tag = "R8 unexpected write"; end
        endcase
        check(act == exp, tag, 64'(act), 64'(exp));
        mDst = mDst + {8'd0, mInc};
        mSrc = mSrc + 16'd1;
      end
    end
  end

  task automatic pushWord(input logic [15:0] w);
    @(negedge clk);
    dataWr = 1; dataWord = w;
    @(negedge clk);
    dataWr = 0;
    hm[3] = hm[2]; hm[2] = hm[1]; hm[1] = hm[0]; hm[0] = w;
  endtask

  task automatic launch(input bit cp, input logic [3:0] cd, input logic [15:0] ln,
                        input logic [15:0] src, input logic [15:0] dst,
                        input logic [7:0] inc, input logic [15:0] fw);
    @(negedge clk);
    expTgt = cp ? 2 : (cd == 4'd1) ? 1 : (cd == 4'd3) ? 3 : (cd == 4'd5) ? 4 : 0;
    mDst = dst; mSrc = src; mInc = inc; mFillHi = fw[15:8];
    wrCnt = 0; busyCnt = 0; wbCnt = 0; wbBusy = 0;
    monOn = 1;
    copyMode = cp; code = cd; len = ln; srcLow = src; dstAddr = dst;
    autoInc = inc; fillWord = fw; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish(input logic [15:0] ln, input logic [15:0] src);
    int steps, writes;
    steps  = (ln == 0) ? 65535 : int'(ln);
    writes = (expTgt == 0) ? 0 : steps;
    while (wbCnt == 0) @(negedge clk);
    @(negedge clk); @(negedge clk);
    monOn = 0;
    check(wrCnt == writes, "R2 R8 write count", 64'(wrCnt), 64'(writes));
    check(busyCnt == steps + 1, "R2 busy cycles", 64'(busyCnt), 64'(steps + 1));
    check(wbCnt == 1 && !wbBusy, "R9 single strobe as busy falls", 64'(wbCnt), 64'd1);
    check(wbLenSeen == 16'd0, "R9 length written back", 64'(wbLenSeen), 64'd0);
    check(wbSrcSeen == src + 16'(steps), "R9 R4 final source", 64'(wbSrcSeen), 64'(src + 16'(steps)));
  endtask

  localparam int NV = 8;
  localparam bit          V_CP   [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};
  localparam logic [3:0]  V_CODE [NV] = '{4'd1, 4'd1, 4'd3, 4'd5, 4'd0, 4'd0, 4'd7, 4'd1};
  localparam logic [15:0] V_LEN  [NV] = '{16'd4, 16'd3, 16'd3, 16'd2, 16'd3, 16'd5, 16'd2, 16'd1};
  localparam logic [15:0] V_SRC  [NV] = '{16'h0100, 16'hFFFE, 16'h0010, 16'h0020,
                                          16'h0030, 16'h2000, 16'h00FF, 16'h1234};
  localparam logic [15:0] V_DST  [NV] = '{16'h1000, 16'hFFFE, 16'h0004, 16'h007E,
                                          16'h0050, 16'h3000, 16'h4000, 16'h5555};
  localparam logic [7:0]  V_INC  [NV] = '{8'd1, 8'd2, 8'd2, 8'd2, 8'd1, 8'd1, 8'd0, 8'd0};
  localparam logic [15:0] V_FILL [NV] = '{16'hAB12, 16'h7F00, 16'h1111, 16'h2222,
                                          16'h3333, 16'h0000, 16'h0000, 16'hCDEF};
  localparam int          V_PUSH [NV] = '{0, 0, 4, 1, 0, 0, 0, 0};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) hm[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy, "R1 reset busy", 64'(busy), 0);
    check(!(vramWe || cramWe || vsramWe), "R1 reset write enables",
          64'({vramWe, cramWe, vsramWe}), 0);
    check(!wbStrobe, "R1 reset strobe", 64'(wbStrobe), 0);

    // R1: history is zero after reset -> scroll fill writes zero
    launch(0, 4'd5, 16'd1, 16'h0000, 16'h0002, 8'd2, 16'hFFFF);
    finish(16'd1, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      for (int p = 0; p < V_PUSH[v]; p++) begin
        pushWord(16'hC3A5 ^ 16'(pushCnt * 16'h0F1D));
        pushCnt++;
      end
      launch(V_CP[v], V_CODE[v], V_LEN[v], V_SRC[v], V_DST[v], V_INC[v], V_FILL[v]);
      finish(V_LEN[v], V_SRC[v]);
    end

    // R10: second start in mid-transfer is ignored
    launch(0, 4'd1, 16'd6, 16'h0400, 16'h0800, 8'd3, 16'h9C00);
    @(negedge clk);
    start = 1; code = 4'd3; dstAddr = 16'h9999; len = 16'd2;
    @(negedge clk);
    start = 0;
    finish(16'd6, 16'h0400);

    // R2: length zero runs 65535 steps
    launch(0, 4'd1, 16'd0, 16'h8000, 16'h0000, 8'd1, 16'h4400);
    finish(16'd0, 16'h8000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule